// File: doc/BRIEF.md
# Triple-Voted State Register

This block holds a small piece of machine state in three independent copies. Each copy has its own next-state logic and its own bitwise majority voter. Every voter reads all three register copies. The voted value feeds that copy's next-state logic, so the register is rewritten from the majority on every clock. A bit upset in one copy is outvoted at once and overwritten on the next edge. A fault inside one voter reaches only that voter's own copy, and that copy is outvoted in the same way. A fault that lasts several cycles in a single copy never reaches the majority seen by the other two copies.

The example state machine is a loadable stepping register. A load takes priority. Otherwise a step adds a fixed increment, and with neither the value holds. The block brings out all three voted values and a flag that shows whether the copies disagree. It also has two fault-injection buses, one for the register copies and one for the voters, so the correction path can be exercised through ports.

Top module: `tmr_state_reg`

## Requirements
- R1: While rst_ni is low, and at the first sample after it is released, all three register copies hold RESET_VAL, every voted output equals RESET_VAL and mismatch_o is low.
- R2: Voted output slice k (bits k*WIDTH to k*WIDTH+WIDTH-1 of voted_o) equals, bit by bit, (a&b)|(b&c)|(a&c) of the three register copies, XORed with the same slice of vote_flip_i. The slice changes combinationally with the copies.
- R3: Each copy computes its next value from its own voted slice. If load_i is 1, the next value is load_val_i, even when step_i is also 1. Otherwise, if step_i is 1, the next value is voted + STEP modulo 2^WIDTH. Otherwise the value holds.
- R4: A nonzero seu_flip_i slice k that is present for one cycle XORs into the value written into copy k at that edge. All three voted outputs keep their fault-free values. mismatch_o is high for the one cycle after that edge, and copy k is healed at the following edge.
- R5: A nonzero vote_flip_i slice k corrupts only voted slice k while it is applied. Only copy k takes the wrong next value. One clock after the fault is removed, all three voted slices agree with the fault-free value again.
- R6: An upset held on one copy's seu_flip_i slice for several consecutive cycles never changes any voted output. The copies agree again one clock after the upset is removed.
- R7: mismatch_o is high exactly when the three register copies are not all equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load load_val_i into the state (priority over step) |
| load_val_i | input | WIDTH | Value to load |
| step_i | input | 1 | Advance the state by STEP |
| seu_flip_i | input | 3*WIDTH | Per-copy XOR mask on the value written into each register copy |
| vote_flip_i | input | 3*WIDTH | Per-voter XOR mask on each voter output |
| voted_o | output | 3*WIDTH | The three voted state values, copy 0 in the low slice |
| mismatch_o | output | 1 | High when the register copies disagree |

## Verification
The bench builds the block with WIDTH=8, STEP=3 and RESET_VAL=8'h5A. An odd step ripples carries through several bits and crosses the 8-bit wrap point after a load near the top of the range. The non-zero reset pattern separates a correct reset from a cleared register. At eight bits, single-bit and multi-bit masks can be injected into every copy and every voter, one domain at a time, including upsets held for several cycles while the state keeps stepping.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Number of redundant domains; the voter structure assumes three.
    localparam int unsigned NUM_DOM = 3;

    // One-bit two-out-of-three majority.
    function automatic logic vote_bit(input logic a, input logic b, input logic c);
        return (a & b) | (b & c) | (a & c);
    endfunction

endpackage

// File: rtl/tmr_voter.sv
module tmr_voter
    import tmr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] copy_a_i,
    input  logic [WIDTH-1:0] copy_b_i,
    input  logic [WIDTH-1:0] copy_c_i,
    input  logic [WIDTH-1:0] fault_i,
    output logic [WIDTH-1:0] vote_o
);

    logic [WIDTH-1:0] maj_w;

    // One majority cell per state bit.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign maj_w[b] = vote_bit(copy_a_i[b], copy_b_i[b], copy_c_i[b]);
    end

    // The fault mask models an upset inside this voter only.
    assign vote_o = maj_w ^ fault_i;

endmodule

// File: rtl/tmr_next_state.sv
module tmr_next_state #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned STEP  = 1
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] nxt_o
);

    localparam logic [WIDTH-1:0] STEP_W = WIDTH'(STEP);

    always_comb begin
        nxt_o = cur_i;
        if (load_i) begin
            nxt_o = load_val_i;
        end else if (step_i) begin
            nxt_o = cur_i + STEP_W;
        end
    end

endmodule

// File: rtl/tmr_domain_reg.sv
module tmr_domain_reg #(
    parameter int unsigned     WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    input  logic [WIDTH-1:0] upset_i,
    output logic [WIDTH-1:0] q_o
);

    typedef struct packed {
        logic [WIDTH-1:0] state;
    } dom_state_t;

    dom_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.state = d_i ^ upset_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.state <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.state;

endmodule

// File: rtl/tmr_state_reg.sv
module tmr_state_reg
    import tmr_pkg::*;
#(
    parameter int unsigned      WIDTH     = 8,
    parameter int unsigned      STEP      = 1,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       load_i,
    input  logic [WIDTH-1:0]           load_val_i,
    input  logic                       step_i,
    input  logic [NUM_DOM*WIDTH-1:0]   seu_flip_i,
    input  logic [NUM_DOM*WIDTH-1:0]   vote_flip_i,
    output logic [NUM_DOM*WIDTH-1:0]   voted_o,
    output logic                       mismatch_o
);

    localparam int unsigned BUS_W = NUM_DOM * WIDTH;

    logic [WIDTH-1:0] copy_q [NUM_DOM];
    logic [WIDTH-1:0] vote_w [NUM_DOM];
    logic [WIDTH-1:0] next_w [NUM_DOM];

    // Each domain: its own voter over all copies, its own next-state logic, its own register.
    for (genvar k = 0; k < NUM_DOM; k++) begin : g_dom
        tmr_voter #(
            .WIDTH (WIDTH)
        ) u_voter (
            .copy_a_i (copy_q[0]),
            .copy_b_i (copy_q[1]),
            .copy_c_i (copy_q[2]),
            .fault_i  (vote_flip_i[k*WIDTH +: WIDTH]),
            .vote_o   (vote_w[k])
        );

        tmr_next_state #(
            .WIDTH (WIDTH),
            .STEP  (STEP)
        ) u_next (
            .cur_i      (vote_w[k]),
            .load_i     (load_i),
            .load_val_i (load_val_i),
            .step_i     (step_i),
            .nxt_o      (next_w[k])
        );

        tmr_domain_reg #(
            .WIDTH     (WIDTH),
            .RESET_VAL (RESET_VAL)
        ) u_reg (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .d_i     (next_w[k]),
            .upset_i (seu_flip_i[k*WIDTH +: WIDTH]),
            .q_o     (copy_q[k])
        );

        assign voted_o[k*WIDTH +: WIDTH] = vote_w[k];
    end

    always_comb begin
        mismatch_o = (copy_q[0] != copy_q[1]) || (copy_q[1] != copy_q[2]);
    end

    // ---------------------------------------------------------------
    // Assertions (the bench injects at most one faulty domain at a time)
    // ---------------------------------------------------------------
    logic no_inj;
    assign no_inj = (seu_flip_i == '0) && (vote_flip_i == '0);

    // R1: first sample after reset release shows the reset pattern everywhere
    a_r1_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(rst_ni) && no_inj) |-> (voted_o == {NUM_DOM{RESET_VAL}}) && !mismatch_o);

    // R3: a load seen by all voters lands in the state one clock later
    a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni && no_inj && load_i) && no_inj)
            |-> voted_o[WIDTH-1:0] == $past(load_val_i));

    // R3: with neither load nor step the voted state holds
    a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni && no_inj && !load_i && !step_i) && no_inj)
            |-> voted_o[WIDTH-1:0] == $past(voted_o[WIDTH-1:0]));

    // R4, R6: once injection stops, a single corrupted copy is rewritten at the next edge
    a_r4_heal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        no_inj |=> !mismatch_o);

    // R2: with no voter fault, all three voted slices agree whenever at most one copy differs
    a_r2_slices_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vote_flip_i == '0) |-> (voted_o[0 +: WIDTH] == voted_o[WIDTH +: WIDTH])
                             && (voted_o[WIDTH +: WIDTH] == voted_o[2*WIDTH +: WIDTH]));

endmodule

// File: tb/tmr_state_reg_bench.sv
module tmr_state_reg_bench;

    localparam int unsigned      WIDTH     = 8;
    localparam int unsigned      STEP      = 3;
    localparam logic [WIDTH-1:0] RESET_VAL = 8'h5A;
    localparam int unsigned      BUS_W     = 3 * WIDTH;

    logic             clk = 1'b0;
    logic             rst_ni;
    logic             load_i;
    logic [WIDTH-1:0] load_val_i;
    logic             step_i;
    logic [BUS_W-1:0] seu_flip_i;
    logic [BUS_W-1:0] vote_flip_i;
    logic [BUS_W-1:0] voted_o;
    logic             mismatch_o;

    always #5 clk = ~clk;

    tmr_state_reg #(
        .WIDTH     (WIDTH),
        .STEP      (STEP),
        .RESET_VAL (RESET_VAL)
    ) u_tmr_state_reg (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .load_i      (load_i),
        .load_val_i  (load_val_i),
        .step_i      (step_i),
        .seu_flip_i  (seu_flip_i),
        .vote_flip_i (vote_flip_i),
        .voted_o     (voted_o),
        .mismatch_o  (mismatch_o)
    );

    typedef struct {
        logic [BUS_W-1:0] voted;
        logic             mism;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done     = 0;

    // Reference model of the three copies, built from R2, R3 and the injection rules
    logic [WIDTH-1:0] mdl [3];

    // Driver: applies one cycle of stimulus at the falling edge and queues the expected view
    task automatic cyc(input logic ld, input logic [WIDTH-1:0] lv, input logic st,
                       input logic [BUS_W-1:0] sf, input logic [BUS_W-1:0] vf,
                       input string tag);
        exp_t e;
        logic [WIDTH-1:0] maj, v, nx;
        @(negedge clk);
        load_i      = ld;
        load_val_i  = lv;
        step_i      = st;
        seu_flip_i  = sf;
        vote_flip_i = vf;
        maj = (mdl[0] & mdl[1]) | (mdl[1] & mdl[2]) | (mdl[0] & mdl[2]);
        e.mism = (mdl[0] != mdl[1]) || (mdl[1] != mdl[2]);
        e.tag  = tag;
        for (int k = 0; k < 3; k++) begin
            v = maj ^ vf[k*WIDTH +: WIDTH];
            e.voted[k*WIDTH +: WIDTH] = v;
            if (ld)      nx = lv;
            else if (st) nx = v + WIDTH'(STEP);
            else         nx = v;
            mdl[k] = nx ^ sf[k*WIDTH +: WIDTH];
        end
        exp_q.push_back(e);
    endtask

    // Monitor: samples shortly after each falling edge and compares against the queue
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_checks++;
                if (voted_o !== e.voted || mismatch_o !== e.mism) begin
                    n_errors++;
                    $display("FAIL %s: voted=%h mismatch=%b expected voted=%h mismatch=%b",
                             e.tag, voted_o, mismatch_o, e.voted, e.mism);
                end
            end
        end
    end

    function automatic logic [BUS_W-1:0] dom(input int k, input logic [WIDTH-1:0] m);
        logic [BUS_W-1:0] r = '0;
        r[k*WIDTH +: WIDTH] = m;
        return r;
    endfunction

    initial begin
        rst_ni      = 1'b0;
        load_i      = 1'b0;
        load_val_i  = '0;
        step_i      = 1'b0;
        seu_flip_i  = '0;
        vote_flip_i = '0;
        for (int k = 0; k < 3; k++) mdl[k] = RESET_VAL;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;

        // R1: reset state visible, hold keeps it
        cyc(0, '0, 0, '0, '0, "R1 reset state");
        cyc(0, '0, 0, '0, '0, "R1 reset hold");

        // R3: stepping, carries, load, load priority, wrap
        cyc(0, '0, 1, '0, '0, "R3 step");
        cyc(0, '0, 1, '0, '0, "R3 step");
        cyc(0, '0, 1, '0, '0, "R3 step");
        cyc(1, 8'hFD, 0, '0, '0, "R3 load");
        cyc(1, 8'h10, 1, '0, '0, "R3 load over step");
        cyc(1, 8'hFE, 0, '0, '0, "R3 load near top");
        cyc(0, '0, 1, '0, '0, "R3 wrap");
        cyc(0, '0, 0, '0, '0, "R3 hold after wrap");

        // R4 / R7: single-cycle upset in each copy, outputs unchanged, heal next edge
        for (int k = 0; k < 3; k++) begin
            cyc(0, '0, 1, dom(k, 8'h08 << k), '0, "R4 upset injected");
            cyc(0, '0, 1, '0, '0, "R7 mismatch while copy corrupt");
            cyc(0, '0, 0, '0, '0, "R4 copy healed");
        end
        cyc(0, '0, 0, dom(1, 8'hFF), '0, "R4 all-bit upset on hold");
        cyc(0, '0, 0, '0, '0, "R7 mismatch after all-bit upset");
        cyc(0, '0, 0, '0, '0, "R4 healed after all-bit upset");

        // R2 / R5: voter fault in one domain
        cyc(0, '0, 1, '0, dom(1, 8'h21), "R2 voter fault visible on own slice");
        cyc(0, '0, 1, '0, '0, "R5 only faulty copy off");
        cyc(0, '0, 0, '0, '0, "R5 voters agree again");
        cyc(1, 8'h3C, 0, '0, dom(2, 8'h80), "R5 voter fault during load");
        cyc(0, '0, 0, '0, '0, "R5 load survives voter fault");
        cyc(0, '0, 0, '0, '0, "R5 settled");
        cyc(0, '0, 1, '0, dom(0, 8'h01), "R2 voter fault domain 0");
        cyc(0, '0, 0, '0, dom(0, 8'h01), "R5 voter fault held");
        cyc(0, '0, 0, '0, '0, "R5 voter fault removed");
        cyc(0, '0, 0, '0, '0, "R5 all agree");

        // R6: upset held for several cycles in one copy while stepping
        for (int i = 0; i < 4; i++) cyc(0, '0, 1, dom(2, 8'h44), '0, "R6 long upset");
        cyc(0, '0, 1, '0, '0, "R6 release");
        cyc(0, '0, 1, '0, '0, "R6 healed");
        for (int i = 0; i < 3; i++) cyc(0, '0, 0, dom(0, 8'h81), '0, "R6 long upset on hold");
        cyc(0, '0, 0, '0, '0, "R6 release on hold");
        cyc(0, '0, 0, '0, '0, "R6 healed on hold");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule